// File: doc/BRIEF.md
# Burst-Gated Transmit FIFO Controller

This block buffers I/Q symbol pairs for a burst transmitter. Each pair arrives as one word, with I in the upper half and Q in the lower half. A symbol-rate read strobe drains the buffer. Reads run in one of two ways. In free-running mode they start on their own once the buffer is primed. In gated mode they follow a transmit enable. When a symbol slot passes with no data, the output can be forced to zero instead of holding the last word.

A full buffer either refuses new words or overwrites its oldest word, and the second case raises an overflow event. A read strobe that finds the buffer empty raises an underflow event. The overflow and underflow events are also the hooks a rate-correction loop would use.

Level flags report the following:
- full and empty;
- a high-water mark and a low-water mark, each against a programmable threshold;
- a pin that is shared between underflow and empty.

Four of these conditions feed an interrupt status register. Each status bit is set on a rising edge and is cleared only by writing a one. A bypass setting routes input pairs straight to the output and leaves the buffer untouched.

Top module: `burst_txfifo_ctrl`

## Requirements
- R1: Words leave the buffer in the order they were written. The buffer holds DEPTH (256) words, and `flag_full` is high exactly when `fill_level` equals DEPTH.
- R2: With `cfg_gated` low, no word is popped until the level has reached 2 at a clock edge. After that, every `sym_rd` pops a word, and this continues until reset.
- R3: With `cfg_gated` high, `sym_rd` pops a word only in cycles where `tx_en` is high. While `tx_en` is low, the level never falls.
- R4: A `sym_rd` cycle that pops no word drives `out_data` to zero on the next cycle when `cfg_zero_fill` is 1, and holds the previous value when it is 0. Every non-bypass `sym_rd` gives `out_valid` high one cycle later.
- R5: With `cfg_block_full` at 1, a write to a full buffer is dropped. The level stays at DEPTH and no overflow event occurs.
- R6: With `cfg_block_full` at 0, a write to a full buffer that is not popped in the same cycle still lands, and the oldest word is discarded. The level stays at DEPTH and `ovf_evt` is high for that cycle.
- R7: A permitted read with the buffer empty raises `udf_evt` for that cycle. It leaves the level unchanged.
- R8: In gated mode, each falling edge of `tx_en` applies one of two behaviours, chosen by `cfg_restart_zero`:
  - When it is 1, the next burst replays from location 0. The level becomes the current write address.
  - When it is 0, the next burst resumes where the last one stopped.
- R9: `flag_hi` is high when the level is at least `cfg_hi_thr`, and `flag_lo` is high when the level is at most `cfg_lo_thr`. `flag_empty` is high when the level is 0.
- R10: `flag_ufe` shows `udf_evt` when `cfg_uf_sel` is 1 and `flag_empty` when it is 0.
- R11: Status bit 0 is overflow, bit 1 is full, bit 2 is underflow and bit 3 is empty. A bit is set at the clock edge where its condition rises (no bit is set by reset). `irq` is high while any set bit has its `irq_mask` bit at 1.
- R12: A set status bit stays set until an `irq_clr` pulse with a 1 in that bit position. Clearing one bit leaves the others unchanged.
- R13: With `cfg_bypass` at 1, an input word appears on `out_data` with `out_valid` high one cycle later. The level and pointers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_data | input | WIDTH | Pair word, I upper half, Q lower half |
| sym_rd | input | 1 | Symbol-rate read strobe |
| tx_en | input | 1 | Transmit enable (gates reads in gated mode) |
| cfg_gated | input | 1 | 1: reads gated by tx_en; 0: auto-start |
| cfg_zero_fill | input | 1 | Zero the output on a slot without data |
| cfg_block_full | input | 1 | Drop writes while full |
| cfg_restart_zero | input | 1 | Replay from location 0 at each burst |
| cfg_bypass | input | 1 | Pass pairs straight through |
| cfg_uf_sel | input | 1 | Shared pin shows underflow (1) or empty (0) |
| cfg_hi_thr | input | CNT_W | High-water threshold |
| cfg_lo_thr | input | CNT_W | Low-water threshold |
| irq_mask | input | 4 | Interrupt enable per status bit |
| irq_clr | input | 4 | Write-one-to-clear pulse per status bit |
| out_valid | output | 1 | Output slot strobe |
| out_data | output | WIDTH | Output pair |
| fill_level | output | CNT_W | Words held |
| flag_full | output | 1 | Buffer full |
| flag_empty | output | 1 | Buffer empty |
| flag_hi | output | 1 | Level at or above high threshold |
| flag_lo | output | 1 | Level at or below low threshold |
| ovf_evt | output | 1 | Overflow event |
| udf_evt | output | 1 | Underflow event |
| flag_ufe | output | 1 | Shared underflow/empty pin |
| irq_status | output | 4 | Interrupt status bits |
| irq | output | 1 | Interrupt request |

## Verification
The checker enforces several invariants on every cycle:
- the level never exceeds the depth, and full and empty never hold together;
- an overflow never fires while blocking is on, and only happens when full;
- an underflow only happens when empty;
- a set status bit survives unless its clear bit was written;
- the level never drops while a gated burst is off;
- zero-fill and bypass put the expected word on the output.

Other behaviours need a whole scenario and only the bench's sequences can show them:
- the exact word order;
- the auto-start after the second write;
- the overwrite of the oldest word on overflow;
- replay from location 0 versus resume across bursts;
- the rising-edge-only setting of status bits.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int NFLAG    = 4;
  localparam int FLG_OVF  = 0;
  localparam int FLG_FULL = 1;
  localparam int FLG_UDF  = 2;
  localparam int FLG_EMPT = 3;

  typedef struct packed {
    logic empty;
    logic udf;
    logic full;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WIDTH-1:0]  wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [WIDTH-1:0]  rd
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/txf_level.sv
module txf_level #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              block_full,
  input  logic              restart,
  output logic              do_push,
  output logic              do_pop,
  output logic              ovf_evt,
  output logic              udf_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    return c + CNT_W'(up) - CNT_W'(dn);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop_req & ~empty;
  assign udf_evt = pop_req & empty;
  assign do_push = push_req & (~full | do_pop | ~block_full);
  assign ovf_evt = push_req & full & ~do_pop & ~block_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      count   <= '0;
    end else begin
      if (do_push) wr_addr <= addr_inc(wr_addr);
      if (restart) begin
        rd_addr <= '0;
        count   <= CNT_W'(wr_addr) + CNT_W'(do_push);
      end else begin
        if (do_pop | ovf_evt) rd_addr <= addr_inc(rd_addr);
        count <= cnt_next(count, do_push & ~ovf_evt, do_pop);
      end
    end
  end
endmodule

// File: rtl/txf_irq.sv
module txf_irq
  import txf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  flags_t           flags,
  input  logic [NFLAG-1:0] mask,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] status,
  output logic             irq
);
  logic [NFLAG-1:0] prev;
  logic [NFLAG-1:0] rise;

  assign rise = flags & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= NFLAG'(1) << FLG_EMPT;
      status <= '0;
    end else begin
      prev   <= flags;
      status <= (status & ~clr) | rise;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/burst_txfifo_ctrl.sv
module burst_txfifo_ctrl
  import txf_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int WIDTH     = 32,
  parameter int PRIME_CNT = 2,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic             sym_rd,
  input  logic             tx_en,
  input  logic             cfg_gated,
  input  logic             cfg_zero_fill,
  input  logic             cfg_block_full,
  input  logic             cfg_restart_zero,
  input  logic             cfg_bypass,
  input  logic             cfg_uf_sel,
  input  logic [CNT_W-1:0] cfg_hi_thr,
  input  logic [CNT_W-1:0] cfg_lo_thr,
  input  logic [3:0]       irq_mask,
  input  logic [3:0]       irq_clr,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic [CNT_W-1:0] fill_level,
  output logic             flag_full,
  output logic             flag_empty,
  output logic             flag_hi,
  output logic             flag_lo,
  output logic             ovf_evt,
  output logic             udf_evt,
  output logic             flag_ufe,
  output logic [3:0]       irq_status,
  output logic             irq
);
  function automatic logic reached(input logic [CNT_W-1:0] lvl);
    return lvl >= CNT_W'(PRIME_CNT);
  endfunction

  logic              tx_q;
  logic              primed;
  logic              burst_end;
  logic              restart;
  logic              rd_enable;
  logic              push_req;
  logic              pop_req;
  logic              do_push;
  logic              do_pop;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [WIDTH-1:0]  rd_word;
  flags_t            flags;

  assign burst_end = cfg_gated & tx_q & ~tx_en;
  assign restart   = burst_end & cfg_restart_zero & ~cfg_bypass;
  assign rd_enable = cfg_gated ? tx_en : primed;
  assign push_req  = in_valid & ~cfg_bypass;
  assign pop_req   = sym_rd & rd_enable & ~cfg_bypass;

  txf_level #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .block_full (cfg_block_full),
    .restart    (restart),
    .do_push    (do_push),
    .do_pop     (do_pop),
    .ovf_evt    (ovf_evt),
    .udf_evt    (udf_evt),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .count      (fill_level),
    .full       (flag_full),
    .empty      (flag_empty)
  );

  txf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk (clk),
    .we  (do_push),
    .wa  (wr_addr),
    .wd  (in_data),
    .ra  (rd_addr),
    .rd  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q      <= 1'b0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      tx_q <= tx_en;
      if (!primed && reached(fill_level)) primed <= 1'b1;
      if (cfg_bypass) begin
        out_valid <= in_valid;
        if (in_valid) out_data <= in_data;
      end else begin
        out_valid <= sym_rd;
        if (do_pop) out_data <= rd_word;
        else if (sym_rd && cfg_zero_fill) out_data <= '0;
      end
    end
  end

  assign flag_hi  = fill_level >= cfg_hi_thr;
  assign flag_lo  = fill_level <= cfg_lo_thr;
  assign flag_ufe = cfg_uf_sel ? udf_evt : flag_empty;

  assign flags.ovf   = ovf_evt;
  assign flags.full  = flag_full;
  assign flags.udf   = udf_evt;
  assign flags.empty = flag_empty;

  txf_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags  (flags),
    .mask   (irq_mask),
    .clr    (irq_clr),
    .status (irq_status),
    .irq    (irq)
  );
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_data,
  input logic             sym_rd,
  input logic             tx_en,
  input logic             cfg_gated,
  input logic             cfg_zero_fill,
  input logic             cfg_block_full,
  input logic             cfg_restart_zero,
  input logic             cfg_bypass,
  input logic [WIDTH-1:0] out_data,
  input logic [CNT_W-1:0] fill_level,
  input logic             flag_full,
  input logic             flag_empty,
  input logic             ovf_evt,
  input logic             udf_evt,
  input logic [3:0]       irq_status,
  input logic [3:0]       irq_clr
);
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  assert_full_empty_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_full && flag_empty));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_block_full |-> !ovf_evt);

  assert_ovf_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_full);

  assert_udf_only_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |-> flag_empty);

  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gated && !tx_en && !cfg_bypass && !cfg_restart_zero)
      |=> fill_level >= $past(fill_level));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_rd && flag_empty && cfg_zero_fill && !cfg_bypass) |=> out_data == '0);

  assert_bypass_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && in_valid) |=> out_data == $past(in_data));

  assert_status_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_status & ~irq_clr))
      |=> ((irq_status & $past(irq_status & ~irq_clr)) == $past(irq_status & ~irq_clr)));
endmodule

bind burst_txfifo_ctrl txf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_data          (in_data),
  .sym_rd           (sym_rd),
  .tx_en            (tx_en),
  .cfg_gated        (cfg_gated),
  .cfg_zero_fill    (cfg_zero_fill),
  .cfg_block_full   (cfg_block_full),
  .cfg_restart_zero (cfg_restart_zero),
  .cfg_bypass       (cfg_bypass),
  .out_data         (out_data),
  .fill_level       (fill_level),
  .flag_full        (flag_full),
  .flag_empty       (flag_empty),
  .ovf_evt          (ovf_evt),
  .udf_evt          (udf_evt),
  .irq_status       (irq_status),
  .irq_clr          (irq_clr)
);

// File: tb/tb_burst_txfifo_ctrl.sv
module tb_burst_txfifo_ctrl;
  localparam int DEPTH = 256;
  localparam int WIDTH = 32;
  localparam int CNT_W = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, in_valid, sym_rd, tx_en;
  logic [WIDTH-1:0] in_data;
  logic             cfg_gated, cfg_zero_fill, cfg_block_full, cfg_restart_zero;
  logic             cfg_bypass, cfg_uf_sel;
  logic [CNT_W-1:0] cfg_hi_thr, cfg_lo_thr;
  logic [3:0]       irq_mask, irq_clr;
  logic             out_valid;
  logic [WIDTH-1:0] out_data;
  logic [CNT_W-1:0] fill_level;
  logic             flag_full, flag_empty, flag_hi, flag_lo, ovf_evt, udf_evt, flag_ufe, irq;
  logic [3:0]       irq_status;

  burst_txfifo_ctrl dut (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; sym_rd = 1'b0; tx_en = 1'b0;
    cfg_gated = 1'b0; cfg_zero_fill = 1'b1; cfg_block_full = 1'b1;
    cfg_restart_zero = 1'b0; cfg_bypass = 1'b0; cfg_uf_sel = 1'b0;
    cfg_hi_thr = 9'd200; cfg_lo_thr = 9'd10; irq_mask = '0; irq_clr = '0;
    step(3);
    rst_n = 1'b1;
    step();
  endtask

  typedef struct packed {
    logic        wv;
    logic [31:0] wd;
    logic        rd;
    logic [8:0]  lvl;
    logic        ov;
    logic [31:0] od;
  } vec_t;

  // Free-running mode, zero-fill on: auto-start after the second write (R2)
  localparam vec_t TBL [10] = '{
    '{1'b1, 32'h000A_000A, 1'b1, 9'd1, 1'b1, 32'h0},
    '{1'b1, 32'h000B_000B, 1'b1, 9'd2, 1'b1, 32'h0},
    '{1'b0, 32'h0,         1'b0, 9'd2, 1'b0, 32'h0},
    '{1'b0, 32'h0,         1'b1, 9'd1, 1'b1, 32'h000A_000A},
    '{1'b1, 32'h000C_000C, 1'b1, 9'd1, 1'b1, 32'h000B_000B},
    '{1'b0, 32'h0,         1'b1, 9'd0, 1'b1, 32'h000C_000C},
    '{1'b0, 32'h0,         1'b1, 9'd0, 1'b1, 32'h0},
    '{1'b1, 32'h000D_000D, 1'b0, 9'd1, 1'b0, 32'h0},
    '{1'b1, 32'h000E_000E, 1'b1, 9'd1, 1'b1, 32'h000D_000D},
    '{1'b0, 32'h0,         1'b1, 9'd0, 1'b1, 32'h000E_000E}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Reset state
    chk("R1", "reset level", 32'(fill_level), 32'd0);
    chk("R9", "reset empty", 32'(flag_empty), 32'd1);
    chk("R1", "reset full", 32'(flag_full), 32'd0);
    chk("R11", "reset status", 32'(irq_status), 32'd0);
    chk("R11", "reset irq", 32'(irq), 32'd0);
    chk("R4", "reset out", out_data, 32'd0);
    chk("R10", "ufe shows empty", 32'(flag_ufe), 32'd1);
    cfg_uf_sel = 1'b1;
    step();
    chk("R10", "ufe shows underflow", 32'(flag_ufe), 32'd0);
    cfg_uf_sel = 1'b0;

    // Vector walk: R1 R2 R4 R7
    for (int i = 0; i < 10; i++) begin
      in_valid = TBL[i].wv; in_data = TBL[i].wd; sym_rd = TBL[i].rd;
      step();
      chk("R2", $sformatf("row %0d level", i), 32'(fill_level), 32'(TBL[i].lvl));
      chk("R4", $sformatf("row %0d valid", i), 32'(out_valid), 32'(TBL[i].ov));
      chk("R1", $sformatf("row %0d data", i), out_data, TBL[i].od);
    end
    in_valid = 1'b0; sym_rd = 1'b0;
    step(2);
    chk("R7", "underflow left level", 32'(fill_level), 32'd0);
    chk("R11", "status udf+empty", 32'(irq_status), 32'b1100);
    chk("R11", "irq masked", 32'(irq), 32'd0);
    irq_mask = 4'b0100;
    step();
    chk("R11", "irq on mask", 32'(irq), 32'd1);
    irq_clr = 4'b1000; step(); irq_clr = 4'b0000;
    step(3);
    chk("R12", "clear one bit only", 32'(irq_status), 32'b0100);
    chk("R12", "irq still set", 32'(irq), 32'd1);
    irq_clr = 4'b0100; step(); irq_clr = 4'b0000;
    step();
    chk("R12", "cleared", 32'(irq_status), 32'd0);
    chk("R12", "irq low", 32'(irq), 32'd0);

    // Fill, block, overflow: R1 R5 R6 R9
    do_reset();
    cfg_zero_fill = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1'b1; in_data = 32'(i); step();
    end
    in_valid = 1'b0;
    chk("R1", "level at depth", 32'(fill_level), 32'd256);
    chk("R1", "full", 32'(flag_full), 32'd1);
    chk("R9", "hi at full", 32'(flag_hi), 32'd1);
    chk("R9", "lo at full", 32'(flag_lo), 32'd0);
    in_valid = 1'b1; in_data = 32'd999; step(); in_valid = 1'b0;
    chk("R5", "blocked write level", 32'(fill_level), 32'd256);
    step();
    chk("R5", "no overflow status", 32'(irq_status[0]), 32'd0);
    chk("R11", "full status", 32'(irq_status[1]), 32'd1);
    sym_rd = 1'b1; step(); sym_rd = 1'b0;
    chk("R1", "first word out", out_data, 32'd0);
    chk("R1", "level after pop", 32'(fill_level), 32'd255);
    cfg_block_full = 1'b0;
    in_valid = 1'b1; in_data = 32'd256; step();
    in_data = 32'd257; step(); in_valid = 1'b0;
    chk("R6", "overflow level", 32'(fill_level), 32'd256);
    step();
    chk("R6", "overflow status", 32'(irq_status[0]), 32'd1);
    sym_rd = 1'b1; step(); sym_rd = 1'b0;
    chk("R6", "oldest dropped", out_data, 32'd2);
    step();
    chk("R4", "hold without zero fill", out_data, 32'd2);

    // Gated bursts: R3 R4 R8
    do_reset();
    cfg_gated = 1'b1;
    sym_rd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = 32'hA0 + 32'(i); step();
      chk("R3", "gated no read", out_data, 32'd0);
    end
    in_valid = 1'b0;
    chk("R3", "level kept", 32'(fill_level), 32'd3);
    tx_en = 1'b1; step();
    chk("R3", "burst word 0", out_data, 32'hA0);
    step();
    chk("R3", "burst word 1", out_data, 32'hA1);
    cfg_zero_fill = 1'b0; tx_en = 1'b0; step();
    chk("R4", "hold when gated off", out_data, 32'hA1);
    chk("R3", "no drain when off", 32'(fill_level), 32'd1);
    cfg_zero_fill = 1'b1; step();
    chk("R4", "zero when gated off", out_data, 32'd0);
    tx_en = 1'b1; step();
    chk("R8", "resume word", out_data, 32'hA2);
    sym_rd = 1'b0; tx_en = 1'b0; step();
    cfg_restart_zero = 1'b1; tx_en = 1'b1; step();
    tx_en = 1'b0; step();
    chk("R8", "replay level", 32'(fill_level), 32'd3);
    tx_en = 1'b1; sym_rd = 1'b1; step(); sym_rd = 1'b0; tx_en = 1'b0;
    chk("R8", "replay from zero", out_data, 32'hA0);

    // Bypass: R13
    cfg_bypass = 1'b1; in_valid = 1'b1; in_data = 32'h1234_5678; step();
    in_valid = 1'b0;
    chk("R13", "bypass data", out_data, 32'h1234_5678);
    chk("R13", "bypass valid", 32'(out_valid), 32'd1);
    chk("R13", "bypass level", 32'(fill_level), 32'd2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule